// File: doc/BRIEF.md
# Processor Interrupt Front End

This block sits between a processor core's external interrupt pins and its sequencer. It takes an asynchronous maskable request line that is level-sensitive, an asynchronous non-maskable request line that reacts to a rising edge, the core's interrupt-enable flag and a one-cycle strobe the core raises in the last clock of every instruction. From these it decides, at each instruction boundary, whether the core must enter an interrupt sequence. When it decides so, it emits a one-cycle take pulse together with the vector type number.

A non-maskable request is remembered from its rising edge until it is serviced. It is serviced at the next instruction boundary whatever the enable flag says, and it carries a fixed vector type. A maskable request is only looked at in the boundary cycle and only when the enable flag is set. Such a request starts a run of back-to-back acknowledge bus cycles of four states each. The active-low acknowledge strobe is driven in the second to fourth state of every cycle. The vector byte is taken from the low data byte in the final state of the last cycle and presented with the take pulse. Fetching the vector table entry, saving flags and running instructions are left to the core.

Top module: `irq_front`

## Requirements
- R1: After reset `ack_n_o` is 1, `take_o` is 0, `vec_type_o` is 0 and no request is pending, so a boundary strobe with both request pins low produces no take pulse and no acknowledge strobe.
- R2: The maskable request pin is only sampled (after its synchronizer) in a cycle where `instr_end_i` is 1 and no acknowledge sequence is running. A request that is held without such a strobe, or that is removed before the strobe, produces nothing.
- R3: A maskable request sampled while `ie_flag_i` is 0 is ignored: no acknowledge strobe and no take pulse.
- R4: An enabled maskable request at a boundary starts, in the next cycle, two acknowledge cycles of four states each, back to back. Over those eight cycles `ack_n_o` reads 1,0,0,0,1,0,0,0, and it is 1 again afterwards.
- R5: The vector byte is the value on `bus_data_i` during the eighth (final) acknowledge cycle, and values present in the other states have no effect. `take_o` is 1 in the cycle after that state and is never 1 while `ack_n_o` is 0.
- R6: A rising edge on `nmi_i` is latched. It is serviced at the next boundary strobe even with `ie_flag_i` at 0: `take_o` rises in the cycle after the strobe with `vec_type_o` = 2, and no acknowledge strobe is produced.
- R7: A non-maskable request is edge-triggered. Holding `nmi_i` high after its service produces no further take pulse until the pin has fallen and risen again.
- R8: Several rising edges on `nmi_i` before one service give a single service. The pending request stays latched, with no time limit, until its service starts.
- R9: When a non-maskable request is pending and an enabled maskable request is present at the same boundary, the non-maskable one is taken with type 2 and no acknowledge starts. The maskable request is still honoured at a later boundary.
- R10: A boundary strobe that arrives while an acknowledge sequence is running has no effect. The sequence neither restarts nor lengthens, and exactly one take pulse results.
- R11: `take_o` is high for exactly one cycle per decision, and `vec_type_o` holds its value until the next take.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| maskreq_i | input | 1 | Maskable interrupt request, level, asynchronous |
| nmi_i | input | 1 | Non-maskable request, rising edge, asynchronous |
| ie_flag_i | input | 1 | Interrupt-enable flag from the core |
| instr_end_i | input | 1 | High in the last clock of each instruction |
| bus_data_i | input | VEC_W (8) | Low data byte of the bus, read during acknowledge |
| ack_n_o | output | 1 | Interrupt acknowledge strobe, active low |
| take_o | output | 1 | One-cycle pulse: enter interrupt sequence |
| vec_type_o | output | VEC_W (8) | Interrupt vector type that goes with `take_o` |

## Verification
The bench builds the block with its defaults: two synchronizer stages, two acknowledge cycles, an 8-bit vector and a non-maskable type of 2. With these values the full eight-state acknowledge pattern, the capture in the final state of the second cycle and the fixed type 2 can all be predicted cycle by cycle. The short synchronizer lets the bench stack several non-maskable edges ahead of one boundary and collide a non-maskable and a maskable request on the same strobe. It also lets the bench place a boundary strobe inside a running acknowledge sequence.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Shared types for the interrupt front end: the bus state encoding used by
// the acknowledge sequencer. Assumes nothing outside this project.
package irq_pkg;

    // States of one acknowledge bus cycle; IDLE means no sequence running.
    typedef enum logic [2:0] {
        BS_IDLE = 3'd0,
        BS_T1   = 3'd1,
        BS_T2   = 3'd2,
        BS_T3   = 3'd3,
        BS_T4   = 3'd4
    } bus_state_e;

endpackage

// File: rtl/irq_sync.sv
// Module irq_sync
// Multi-stage synchronizer for one asynchronous level input.
// Assumes STAGES >= 2; output lags the pin by STAGES clocks; resets to 0.
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the pin value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/nmi_latch.sv
// Module nmi_latch
// Detects a rising edge on an already synchronized level and holds a
// pending flag until service clears it. Assumes lvl_i is synchronous.
// An edge in the same cycle as a clear survives as a fresh request.
module nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic clr_i,
    output logic pend_o
);

    logic prev_q;
    logic pend_q;
    logic rise;

    assign rise = lvl_i && !prev_q;

    // Remember the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
        end
    end

    // Set on an edge, clear on service; extra edges merge into one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q && !clr_i) || rise;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/inta_seq.sv
// Module inta_seq
// Runs ACK_CYCLES back-to-back four-state acknowledge cycles after a start
// pulse. Drives the active-low acknowledge in states 2..4 and flags the
// final state of the last cycle, where the vector byte is to be captured.
// Assumes start_i is only honoured while idle.
module inta_seq
    import irq_pkg::*;
#(
    parameter int ACK_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic idle_o,
    output logic ack_n_o,
    output logic done_o
);

    localparam int CYC_W = (ACK_CYCLES > 1) ? $clog2(ACK_CYCLES) : 1;
    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(ACK_CYCLES - 1);

    bus_state_e       st_q;
    logic [CYC_W-1:0] cyc_q;

    // Advance through T1..T4, repeating per acknowledge cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BS_IDLE;
            cyc_q <= '0;
        end else begin
            unique case (st_q)
                BS_IDLE: begin
                    if (start_i) begin
                        st_q  <= BS_T1;
                        cyc_q <= '0;
                    end
                end
                BS_T1: st_q <= BS_T2;
                BS_T2: st_q <= BS_T3;
                BS_T3: st_q <= BS_T4;
                BS_T4: begin
                    if (cyc_q == LAST_CYC) begin
                        st_q <= BS_IDLE;
                    end else begin
                        st_q  <= BS_T1;
                        cyc_q <= cyc_q + 1'b1;
                    end
                end
                default: st_q <= BS_IDLE;
            endcase
        end
    end

    // Decode bus outputs from the current state.
    always_comb begin
        idle_o  = (st_q == BS_IDLE);
        ack_n_o = !((st_q == BS_T2) || (st_q == BS_T3) || (st_q == BS_T4));
        done_o  = (st_q == BS_T4) && (cyc_q == LAST_CYC);
    end

endmodule

// File: rtl/irq_front.sv
// Module irq_front
// Interrupt front end of a processor core. Synchronizes the request pins,
// latches non-maskable edges, decides at each instruction boundary and
// runs the acknowledge handshake for maskable requests.
// Assumes instr_end_i and ie_flag_i are synchronous to clk.
module irq_front #(
    parameter int SYNC_STAGES = 2,
    parameter int ACK_CYCLES  = 2,
    parameter int VEC_W       = 8,
    parameter int NMI_TYPE    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             maskreq_i,
    input  logic             nmi_i,
    input  logic             ie_flag_i,
    input  logic             instr_end_i,
    input  logic [VEC_W-1:0] bus_data_i,
    output logic             ack_n_o,
    output logic             take_o,
    output logic [VEC_W-1:0] vec_type_o
);

    localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NMI_TYPE);

    logic             mreq_s;
    logic             nmi_s;
    logic             nmi_pend;
    logic             seq_idle;
    logic             seq_done;
    logic             boundary;
    logic             nmi_go;
    logic             intr_go;
    logic             take_q;
    logic [VEC_W-1:0] vec_q;

    irq_sync #(.STAGES(SYNC_STAGES)) u_sync_mreq (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (maskreq_i),
        .sync_o  (mreq_s)
    );

    irq_sync #(.STAGES(SYNC_STAGES)) u_sync_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (nmi_i),
        .sync_o  (nmi_s)
    );

    nmi_latch u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (nmi_s),
        .clr_i  (nmi_go),
        .pend_o (nmi_pend)
    );

    inta_seq #(.ACK_CYCLES(ACK_CYCLES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (intr_go),
        .idle_o  (seq_idle),
        .ack_n_o (ack_n_o),
        .done_o  (seq_done)
    );

    // Boundary decision: non-maskable first, then enabled maskable.
    always_comb begin
        boundary = instr_end_i && seq_idle;
        nmi_go   = boundary && nmi_pend;
        intr_go  = boundary && !nmi_pend && mreq_s && ie_flag_i;
    end

    // Register the take pulse and the vector that goes with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            take_q <= nmi_go || seq_done;
            if (nmi_go) begin
                vec_q <= NMI_VEC;
            end else if (seq_done) begin
                vec_q <= bus_data_i;
            end
        end
    end

    assign take_o     = take_q;
    assign vec_type_o = vec_q;

endmodule

// File: rtl/irq_front_chk.sv
// Module irq_front_chk
// Property checker for irq_front, attached with bind. Observes ports and
// the internal service and pending signals.
module irq_front_chk #(
    parameter int VEC_W    = 8,
    parameter int NMI_TYPE = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_n_o,
    input logic             take_o,
    input logic [VEC_W-1:0] vec_type_o,
    input logic             nmi_go,
    input logic             nmi_pend
);

    // R11: take pulse lasts one cycle.
    assert_take_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R4: each acknowledge strobe is low for exactly three states.
    assert_ack_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n_o) |=> !ack_n_o ##1 !ack_n_o ##1 ack_n_o);

    // R5: no take while the acknowledge strobe is active.
    assert_take_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ack_n_o);

    // R6: non-maskable service yields the fixed type next cycle.
    assert_nmi_type_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_go |=> (take_o && vec_type_o == VEC_W'(NMI_TYPE)));

    // R8: a pending request survives until its service starts.
    assert_nmi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !nmi_go) |=> nmi_pend);

endmodule

bind irq_front irq_front_chk #(
    .VEC_W    (VEC_W),
    .NMI_TYPE (NMI_TYPE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_n_o    (ack_n_o),
    .take_o     (take_o),
    .vec_type_o (vec_type_o),
    .nmi_go     (nmi_go),
    .nmi_pend   (nmi_pend)
);

// File: tb/irq_front_test.sv
// Bench for irq_front: driver tasks push expected vectors into a queue,
// a monitor pops and compares on every take pulse.
module irq_front_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       maskreq_i = 1'b0;
    logic       nmi_i = 1'b0;
    logic       ie_flag_i = 1'b0;
    logic       instr_end_i = 1'b0;
    logic [7:0] bus_data_i = 8'h00;
    logic       ack_n_o;
    logic       take_o;
    logic [7:0] vec_type_o;

    int    n_chk = 0;
    int    n_bad = 0;
    int    ack_lows = 0;
    bit    finished = 0;
    string cur_tag = "R1";
    logic [7:0] exp_vec[$];
    string      exp_tag[$];

    always #2 clk = ~clk;

    irq_front uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .maskreq_i   (maskreq_i),
        .nmi_i       (nmi_i),
        .ie_flag_i   (ie_flag_i),
        .instr_end_i (instr_end_i),
        .bus_data_i  (bus_data_i),
        .ack_n_o     (ack_n_o),
        .take_o      (take_o),
        .vec_type_o  (vec_type_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] v, input string tag);
        exp_vec.push_back(v);
        exp_tag.push_back(tag);
    endtask

    task automatic pulse_end();
        instr_end_i = 1'b1;
        @(negedge clk);
        instr_end_i = 1'b0;
    endtask

    // No acknowledge strobe and no pending expectation over a window.
    task automatic check_quiet(input string tag, input int cycles);
        int lows0;
        lows0 = ack_lows;
        tick(cycles);
        check(ack_lows == lows0, tag, ack_lows - lows0, 0);
        check(exp_vec.size() == 0, tag, exp_vec.size(), 0);
    endtask

    // Maskable service: check the eight-state strobe pattern; byte only valid in final state.
    task automatic do_intr(input logic [7:0] data, input bit mid_end, input string tag);
        push(data, tag);
        bus_data_i  = ~data;
        instr_end_i = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (k == 1) instr_end_i = 1'b0;
            if (mid_end && k == 3) instr_end_i = 1'b1;
            if (mid_end && k == 4) instr_end_i = 1'b0;
            check(ack_n_o == ((k == 1 || k == 5) ? 1'b1 : 1'b0), "R4", ack_n_o, (k == 1 || k == 5));
            bus_data_i = (k == 8) ? data : ~data;
        end
        @(negedge clk);
        bus_data_i = ~data;
        tick(2);
    endtask

    // Scoreboard monitor: every take must match the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && !ack_n_o) ack_lows++;
        if (rst_n && take_o) begin
            if (exp_vec.size() == 0) begin
                check(1'b0, cur_tag, vec_type_o, 0);
            end else begin
                logic [7:0] ev;
                string      et;
                ev = exp_vec.pop_front();
                et = exp_tag.pop_front();
                check(vec_type_o == ev, et, vec_type_o, ev);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1: reset values and nothing pending.
        cur_tag = "R1";
        check(ack_n_o == 1'b1, "R1", ack_n_o, 1);
        check(take_o == 1'b0, "R1", take_o, 0);
        check(vec_type_o == 8'h00, "R1", vec_type_o, 0);
        pulse_end();
        check_quiet("R1", 4);

        // R2: held request without strobe, then removed before strobe.
        cur_tag = "R2";
        ie_flag_i = 1'b1;
        maskreq_i = 1'b1;
        check_quiet("R2", 20);
        maskreq_i = 1'b0;
        tick(4);
        pulse_end();
        check_quiet("R2", 6);

        // R3: enable flag clear masks the request.
        cur_tag = "R3";
        ie_flag_i = 1'b0;
        maskreq_i = 1'b1;
        tick(4);
        pulse_end();
        check_quiet("R3", 12);

        // R4 / R5: two maskable services with different bytes.
        cur_tag = "R5";
        ie_flag_i = 1'b1;
        do_intr(8'h3C, 1'b0, "R5");
        do_intr(8'hC3, 1'b0, "R5");
        check_quiet("R5", 2);

        // R10: strobe inside the running sequence is ignored.
        cur_tag = "R10";
        do_intr(8'h81, 1'b1, "R10");
        maskreq_i = 1'b0;
        check_quiet("R10", 10);

        // R6: edge serviced with enable clear, type 2, no strobe.
        cur_tag = "R6";
        ie_flag_i = 1'b0;
        nmi_i = 1'b1;
        tick(5);
        push(8'h02, "R6");
        pulse_end();
        check_quiet("R6", 4);

        // R11: vector holds after the pulse.
        check(take_o == 1'b0, "R11", take_o, 0);
        check(vec_type_o == 8'h02, "R11", vec_type_o, 2);

        // R7: level held high does not retrigger.
        cur_tag = "R7";
        tick(4);
        pulse_end();
        check_quiet("R7", 6);
        nmi_i = 1'b0;
        tick(4);
        nmi_i = 1'b1;
        tick(5);
        push(8'h02, "R7");
        pulse_end();
        check_quiet("R7", 4);

        // R8: two edges merge into one service, latch holds long.
        cur_tag = "R8";
        nmi_i = 1'b0;
        tick(4);
        nmi_i = 1'b1;
        tick(4);
        nmi_i = 1'b0;
        tick(4);
        nmi_i = 1'b1;
        tick(40);
        push(8'h02, "R8");
        pulse_end();
        tick(3);
        pulse_end();
        check_quiet("R8", 6);

        // R9: both pending at one strobe, non-maskable wins.
        cur_tag = "R9";
        nmi_i = 1'b0;
        tick(4);
        ie_flag_i = 1'b1;
        maskreq_i = 1'b1;
        nmi_i = 1'b1;
        tick(5);
        push(8'h02, "R9");
        pulse_end();
        check_quiet("R9", 3);
        do_intr(8'h5A, 1'b0, "R9");
        maskreq_i = 1'b0;
        check_quiet("R9", 6);

        // R11: vector from last maskable service still held.
        check(vec_type_o == 8'h5A, "R11", vec_type_o, 8'h5A);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule